// File: doc/BRIEF.md
# Tone Transceiver Status and Interrupt Register

This block holds the four-bit status word of a tone transceiver and drives its interrupt request pin. Three event flags latch one-clock pulses from neighbouring logic: one from the burst sequencer when a tone burst's pause has ended, and one from the receiver when a decoded digit has been stored. A summary flag is raised by either of those events. A fourth bit is a registered copy of the detector's delayed steering level.

The host reads the status word through a one-cycle read strobe. During the strobe cycle the word shows its value from before the read. On the following edge the three latched flags clear. If an event arrives in the same cycle as that read, the event is kept rather than lost.

The interrupt pin is active-low. It is asserted while the summary flag is set and interrupts are enabled. When test mode is on and the transceiver is in dual-tone mode (call-progress mode off), the pin stops acting as an interrupt and instead shows the registered steering bit.

Top module: `tone_status_irq`

## Requirements
- R1: While `rstN` is low at a rising clock edge, status bits 0 to 2 are loaded with 0 and bit 3 is loaded with the level on `steerDelayed`.
- R2: If `txReadyPulse` is high while `burstOn` is high, status bit 1 (transmit ready) and bit 0 (summary) are both 1 after the next edge.
- R3: If `rxValidPulse` is high, status bit 2 (receive full) and bit 0 (summary) are both 1 after the next edge.
- R4: While `statusRd` is high, `statusWord` still shows the value from before the read. After that edge, bits 0 to 2 are 0, unless a set event arrived in the same cycle.
- R5: A set event in the same cycle as `statusRd` wins: its flag and bit 0 are 1 after the edge.
- R6: While `burstOn` is low, bit 1 is 0 after each edge, and a `txReadyPulse` changes neither bit 1 nor bit 0.
- R7: Bit 3 takes the value of `steerDelayed` at each edge. A 1 means a tone pair is confirmed absent; a 0 means a valid tone pair is present.
- R8: When the pin is not mirroring, `irqN` is 0 exactly when bit 0 is 1 and `irqEnable` is 1; otherwise `irqN` is 1.
- R9: When `testMode` is 1 and `cpMode` is 0, `irqN` equals bit 3. When `testMode` is 1 and `cpMode` is 1, the pin follows R8.
- R10: A status read leaves bit 3 unchanged; bit 3 depends only on `steerDelayed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| burstOn | input | 1 | Burst mode active |
| txReadyPulse | input | 1 | One-cycle pulse marking the end of a burst pause |
| rxValidPulse | input | 1 | One-cycle pulse marking a stored received digit |
| steerDelayed | input | 1 | Delayed steering level from the detector (1 = tone pair absent) |
| statusRd | input | 1 | One-cycle status read strobe from the host bus |
| irqEnable | input | 1 | Interrupt output enable |
| testMode | input | 1 | Test mode control |
| cpMode | input | 1 | Call-progress mode (0 = dual-tone mode) |
| statusWord | output | 4 | Status word: bit 0 summary, bit 1 transmit ready, bit 2 receive full, bit 3 delayed steering |
| irqN | output | 1 | Interrupt pin, active low, multiplexed in test mode |

## Verification
The block has a single build. The bit positions of the status word are fixed by what the host decodes, so the bench uses the one configuration the package defines, and every bit of the word is observable at the ports. In that build the bench can create the cycle-exact collisions between read strobes and set pulses. It can also turn burst mode off while transmit ready is set, and it can walk all four combinations of test mode and call-progress mode while the steering level and the summary flag disagree.

// File: rtl/tone_status_pkg.sv
package tone_status_pkg;

  // Bit positions the host decodes
  localparam int unsigned STATUS_W = 4;
  localparam int unsigned BIT_SUM  = 0;
  localparam int unsigned BIT_TX   = 1;
  localparam int unsigned BIT_RX   = 2;
  localparam int unsigned BIT_STR  = 3;

  typedef logic [STATUS_W-1:0] statusWord_t;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic setTx;      // transmit-ready event accepted
    logic setRx;      // receive-full event accepted
    logic clrRead;    // host read clears event flags
    logic dropTx;     // burst mode off forces transmit-ready low
    logic mirrorPin;  // pin shows steering instead of interrupt
  } statusCtl_t;

endpackage

// File: rtl/tone_status_ctrl.sv
module tone_status_ctrl
  import tone_status_pkg::*;
(
  input  logic       burstOn,
  input  logic       txReadyPulse,
  input  logic       rxValidPulse,
  input  logic       statusRd,
  input  logic       testMode,
  input  logic       cpMode,
  output statusCtl_t ctl
);

  always_comb begin
    ctl           = '0;
    // Transmit-ready events only count while bursts are in use
    ctl.setTx     = txReadyPulse & burstOn;
    ctl.setRx     = rxValidPulse;
    ctl.clrRead   = statusRd;
    ctl.dropTx    = ~burstOn;
    // Test mode in dual-tone mode repurposes the pin
    ctl.mirrorPin = testMode & ~cpMode;
  end

endmodule

// File: rtl/tone_status_dp.sv
module tone_status_dp
  import tone_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  statusCtl_t  ctl,
  input  logic        steerDelayed,
  input  logic        irqEnable,
  output statusWord_t statusWord,
  output logic        irqN
);

  statusWord_t flagQ;
  statusWord_t flagD;

  // Next-state: a set event wins over a clearing read
  always_comb begin
    flagD = flagQ;

    if (ctl.clrRead) begin
      flagD[BIT_SUM] = 1'b0;
      flagD[BIT_TX]  = 1'b0;
      flagD[BIT_RX]  = 1'b0;
    end

    if (ctl.dropTx) begin
      flagD[BIT_TX] = 1'b0;
    end

    if (ctl.setTx) begin
      flagD[BIT_TX]  = 1'b1;
      flagD[BIT_SUM] = 1'b1;
    end

    if (ctl.setRx) begin
      flagD[BIT_RX]  = 1'b1;
      flagD[BIT_SUM] = 1'b1;
    end

    flagD[BIT_STR] = steerDelayed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ          <= '0;
      flagQ[BIT_STR] <= steerDelayed;
    end else begin
      flagQ <= flagD;
    end
  end

  assign statusWord = flagQ;

  always_comb begin
    if (ctl.mirrorPin) begin
      irqN = flagQ[BIT_STR];
    end else begin
      irqN = ~(flagQ[BIT_SUM] & irqEnable);
    end
  end

endmodule

// File: rtl/tone_status_irq.sv
module tone_status_irq
  import tone_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstOn,
  input  logic                txReadyPulse,
  input  logic                rxValidPulse,
  input  logic                steerDelayed,
  input  logic                statusRd,
  input  logic                irqEnable,
  input  logic                testMode,
  input  logic                cpMode,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irqN
);

  statusCtl_t ctl;

  tone_status_ctrl i_ctrl (
    .burstOn      (burstOn),
    .txReadyPulse (txReadyPulse),
    .rxValidPulse (rxValidPulse),
    .statusRd     (statusRd),
    .testMode     (testMode),
    .cpMode       (cpMode),
    .ctl          (ctl)
  );

  tone_status_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .steerDelayed (steerDelayed),
    .irqEnable    (irqEnable),
    .statusWord   (statusWord),
    .irqN         (irqN)
  );

endmodule

// File: rtl/tone_status_chk.sv
module tone_status_chk
  import tone_status_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                burstOn,
  input logic                txReadyPulse,
  input logic                rxValidPulse,
  input logic                steerDelayed,
  input logic                statusRd,
  input logic                irqEnable,
  input logic                testMode,
  input logic                cpMode,
  input logic [STATUS_W-1:0] statusWord,
  input logic                irqN
);

  p_tx_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txReadyPulse && burstOn) |=> (statusWord[BIT_TX] && statusWord[BIT_SUM]));

  p_rx_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValidPulse |=> (statusWord[BIT_RX] && statusWord[BIT_SUM]));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValidPulse && !(txReadyPulse && burstOn))
      |=> (statusWord[BIT_RX:BIT_SUM] == 3'b000));

  p_burst_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !burstOn |=> !statusWord[BIT_TX]);

  p_steer_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[BIT_STR] == $past(steerDelayed)));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode || cpMode) |-> (irqN == !(statusWord[BIT_SUM] && irqEnable)));

  p_pin_mirror_r9: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !cpMode) |-> (irqN == statusWord[BIT_STR]));

endmodule

bind tone_status_irq tone_status_chk i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .burstOn      (burstOn),
  .txReadyPulse (txReadyPulse),
  .rxValidPulse (rxValidPulse),
  .steerDelayed (steerDelayed),
  .statusRd     (statusRd),
  .irqEnable    (irqEnable),
  .testMode     (testMode),
  .cpMode       (cpMode),
  .statusWord   (statusWord),
  .irqN         (irqN)
);

// File: tb/test_tone_status_irq.sv
module test_tone_status_irq;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN;
  logic       burstOn, txReadyPulse, rxValidPulse, steerDelayed;
  logic       statusRd, irqEnable, testMode, cpMode;
  logic [3:0] statusWord;
  logic       irqN;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_status_irq i_tone_status_irq (
    .clk(clk), .rstN(rstN), .burstOn(burstOn), .txReadyPulse(txReadyPulse),
    .rxValidPulse(rxValidPulse), .steerDelayed(steerDelayed), .statusRd(statusRd),
    .irqEnable(irqEnable), .testMode(testMode), .cpMode(cpMode),
    .statusWord(statusWord), .irqN(irqN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    txReadyPulse = 0; rxValidPulse = 0; statusRd = 0;
  endtask

  task automatic doReset(input logic steer);
    rstN = 0; steerDelayed = steer; burstOn = 1; idle();
    irqEnable = 0; testMode = 0; cpMode = 0;
    tick(); tick();
    rstN = 1;
  endtask

  task automatic testReset();
    doReset(1'b1);
    chk("R1 reset word steer=1", statusWord, 4'b1000);
    doReset(1'b0);
    chk("R1 reset word steer=0", statusWord, 4'b0000);
    chk("R8 pin idle", {3'b0, irqN}, 4'b0001);
  endtask

  task automatic testTxSet();
    doReset(1'b0);
    txReadyPulse = 1; tick(); idle();
    chk("R2 tx event", statusWord, 4'b0011);
    statusRd = 1;
    chk("R4 pre-clear value", statusWord, 4'b0011);
    tick(); idle();
    chk("R4 cleared after read", statusWord, 4'b0000);
  endtask

  task automatic testRxSet();
    doReset(1'b0);
    rxValidPulse = 1; tick(); idle();
    chk("R3 rx event", statusWord, 4'b0101);
    tick();
    chk("R3 flags hold", statusWord, 4'b0101);
    statusRd = 1; tick(); idle();
    chk("R4 rx cleared", statusWord, 4'b0000);
  endtask

  task automatic testCollision();
    doReset(1'b0);
    txReadyPulse = 1; tick(); idle();
    statusRd = 1; rxValidPulse = 1; tick(); idle();
    chk("R5 rx wins over read", statusWord, 4'b0101);
    statusRd = 1; txReadyPulse = 1; tick(); idle();
    chk("R5 tx wins over read", statusWord, 4'b0011);
  endtask

  task automatic testBurstOff();
    doReset(1'b0);
    txReadyPulse = 1; tick(); idle();
    burstOn = 0; tick();
    chk("R6 burst off drops bit1", statusWord, 4'b0001);
    statusRd = 1; tick(); idle();
    txReadyPulse = 1; tick(); idle();
    chk("R6 tx ignored when burst off", statusWord, 4'b0000);
    burstOn = 1;
  endtask

  task automatic testSteer();
    doReset(1'b0);
    steerDelayed = 1; tick();
    chk("R7 steer set", statusWord, 4'b1000);
    statusRd = 1; tick(); idle();
    chk("R10 read keeps bit3", statusWord, 4'b1000);
    steerDelayed = 0; tick();
    chk("R7 steer cleared", statusWord, 4'b0000);
  endtask

  task automatic testIrqPin();
    doReset(1'b0);
    rxValidPulse = 1; tick(); idle();
    chk("R8 disabled pin high", {3'b0, irqN}, 4'b0001);
    irqEnable = 1; #1;
    chk("R8 enabled pin low", {3'b0, irqN}, 4'b0000);
    statusRd = 1; tick(); idle();
    chk("R8 pin released after read", {3'b0, irqN}, 4'b0001);
  endtask

  task automatic testMirror();
    doReset(1'b0);
    irqEnable = 1;
    rxValidPulse = 1; tick(); idle();
    testMode = 1; cpMode = 0; #1;
    chk("R9 mirror steer=0", {3'b0, irqN}, 4'b0000);
    steerDelayed = 1; tick();
    chk("R9 mirror steer=1 despite irq", {3'b0, irqN}, 4'b0001);
    cpMode = 1; #1;
    chk("R9 cp mode keeps irq", {3'b0, irqN}, 4'b0000);
    testMode = 0; cpMode = 0; #1;
    chk("R8 normal pin low", {3'b0, irqN}, 4'b0000);
  endtask

  initial begin
    fork
      begin
        testReset();
        testTxSet();
        testRxSet();
        testCollision();
        testBurstOff();
        testSteer();
        testIrqPin();
        testMirror();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule